// File: doc/BRIEF.md
# Hardware Cursor Overlay

This block lays a 16x16 two-plane cursor over a stream of video pixels. Each cursor row is described by two 16-bit words. A mask word says which columns the cursor hides, and a shape word gives the cursor bit shown in every hidden column. The pixel stream carries its screen coordinates alongside each pixel. The block compares those coordinates with a latched cursor origin and replaces a covered pixel with all ones or all zeros, as the shape bit dictates. Every other pixel passes through untouched.

Software loads the cursor with a plain word-write port into a shared memory space of 2^MEM_AW words. Only the top 32 words of that space belong to the cursor. Of these, the lower 16 hold the mask rows and the upper 16 hold the shape rows, each in row order. The cursor origin is taken from two control inputs, and only when a frame-start pulse arrives, so the cursor never moves part-way through a frame.

The pixel interface follows valid/ready rules. An input pixel is accepted on a clock edge where `in_valid` and `in_ready` are both high. Its result is held in a single output register. While `out_valid` is high and `out_ready` is low, that result stays fixed and `in_ready` is low, so back-pressure passes straight through to the source.

Top module: `cursor_overlay`

## Requirements
- R1: After reset, `out_valid` is 0, `in_ready` is 1, all mask and shape rows are zero and the cursor origin is (0,0), so every pixel passes through unchanged.
- R2: A write lands in the cursor only when the top MEM_AW-5 address bits are all ones. With the low 5 address bits as offset, offsets 0..15 set mask row 0..15 and offsets 16..31 set shape row 0..15. Writes to any lower address change nothing visible at the output.
- R3: A pixel at (x,y) is covered when 0 <= x-cx < 16 and 0 <= y-cy < 16, where (cx,cy) is the latched cursor origin. Row index = y-cy and column index = x-cx.
- R4: Column c of a row uses bit 15-c of that row's words, so bit 15 is the leftmost cursor column.
- R5: A covered pixel whose mask bit is 1 and shape bit is 1 is output as all ones.
- R6: A covered pixel whose mask bit is 1 and shape bit is 0 is output as all zeros.
- R7: A pixel that is not covered, or whose mask bit is 0, is output equal to its input value.
- R8: The cursor origin takes the values on `cur_x`/`cur_y` only on a clock edge where `frame_start` is 1. At any other edge, changes on those inputs have no effect.
- R9: A pixel accepted at an edge appears on `out_pix` with `out_valid` high immediately after that edge. While `out_valid` is 1 and `out_ready` is 0, `out_valid` and `out_pix` hold.
- R10: `in_ready` is 1 exactly when `out_valid` is 0 or `out_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Word write strobe |
| wr_addr | input | MEM_AW | Word address in the shared space |
| wr_data | input | 16 | Word to write |
| frame_start | input | 1 | Latches the cursor origin |
| cur_x | input | COORD_W | Cursor origin column |
| cur_y | input | COORD_W | Cursor origin line |
| in_valid | input | 1 | Input pixel valid |
| in_ready | output | 1 | Input pixel may be accepted |
| in_x | input | COORD_W | Column of the input pixel |
| in_y | input | COORD_W | Line of the input pixel |
| in_pix | input | PIX_W | Input pixel value |
| out_valid | output | 1 | Output pixel valid |
| out_ready | input | 1 | Downstream accepts the output pixel |
| out_pix | output | PIX_W | Output pixel value |

## Verification
A result is due one clock edge after its pixel is accepted. Row writes and origin latches act from the edge that follows them. The bench drives inputs on the falling edge and lets one rising edge accept the pixel. It then samples `out_pix` on the next falling edge, where the single register has settled. A sweep of a 20x20 window around the cursor compares every pixel against a value computed from the row patterns. Separate back-pressure steps hold `out_ready` low across a rising edge and confirm that the result and `in_ready` stay put.

// File: rtl/cursor_pkg.sv
package cursor_pkg;
  localparam int CUR_DIM = 16;
  localparam int IDX_W   = $clog2(CUR_DIM);
  localparam int WIN_W   = IDX_W + 1;
  typedef logic [CUR_DIM-1:0] row_t;
  typedef logic [IDX_W-1:0]   idx_t;
endpackage

// File: rtl/cursor_store.sv
module cursor_store
  import cursor_pkg::*;
#(
  parameter int MEM_AW = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [MEM_AW-1:0] wr_addr,
  input  logic [15:0]       wr_data,
  input  idx_t              rd_row,
  output row_t              mask_row,
  output row_t              shape_row
);
  localparam int HI_W = MEM_AW - WIN_W;

  row_t [CUR_DIM-1:0] mask_q;
  row_t [CUR_DIM-1:0] shape_q;

  logic in_win;
  logic plane_sel;
  idx_t wr_row;

  assign in_win    = wr_en && (&wr_addr[MEM_AW-1 -: HI_W]);
  assign plane_sel = wr_addr[WIN_W-1];
  assign wr_row    = wr_addr[IDX_W-1:0];

  for (genvar r = 0; r < CUR_DIM; r++) begin : g_row
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        mask_q[r]  <= '0;
        shape_q[r] <= '0;
      end else if (in_win && wr_row == idx_t'(r)) begin
        if (plane_sel) shape_q[r] <= wr_data;
        else           mask_q[r]  <= wr_data;
      end
    end
  end

  assign mask_row  = mask_q[rd_row];
  assign shape_row = shape_q[rd_row];

  assert_low_write_ignored_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !(&wr_addr[MEM_AW-1 -: HI_W])) |=> ($stable(mask_q) && $stable(shape_q)));
endmodule

// File: rtl/cursor_hit.sv
module cursor_hit
  import cursor_pkg::*;
#(
  parameter int COORD_W = 11
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               frame_start,
  input  logic [COORD_W-1:0] cur_x,
  input  logic [COORD_W-1:0] cur_y,
  input  logic [COORD_W-1:0] pix_x,
  input  logic [COORD_W-1:0] pix_y,
  output logic               hit,
  output idx_t               row,
  output idx_t               col
);
  logic [COORD_W-1:0] cx_q, cy_q;
  logic [COORD_W:0]   dx, dy;
  logic               in_x, in_y;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cx_q <= '0;
      cy_q <= '0;
    end else if (frame_start) begin
      cx_q <= cur_x;
      cy_q <= cur_y;
    end
  end

  assign dx   = {1'b0, pix_x} - {1'b0, cx_q};
  assign dy   = {1'b0, pix_y} - {1'b0, cy_q};
  assign in_x = (dx[COORD_W:IDX_W] == '0);
  assign in_y = (dy[COORD_W:IDX_W] == '0);
  assign hit  = in_x && in_y;
  assign col  = dx[IDX_W-1:0];
  assign row  = dy[IDX_W-1:0];

  assert_origin_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_start |=> ($stable(cx_q) && $stable(cy_q)));
endmodule

// File: rtl/cursor_mix.sv
module cursor_mix
  import cursor_pkg::*;
#(
  parameter int PIX_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [PIX_W-1:0] in_pix,
  input  logic             hit,
  input  row_t             mask_row,
  input  row_t             shape_row,
  input  idx_t             col,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [PIX_W-1:0] out_pix
);
  idx_t             bit_idx;
  logic             hide, shape_bit, take;
  logic [PIX_W-1:0] mixed;

  assign bit_idx   = ~col;
  assign hide      = hit && mask_row[bit_idx];
  assign shape_bit = shape_row[bit_idx];
  assign mixed     = hide ? {PIX_W{shape_bit}} : in_pix;
  assign in_ready  = !out_valid || out_ready;
  assign take      = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_pix   <= '0;
    end else begin
      if (take)           out_valid <= 1'b1;
      else if (out_ready) out_valid <= 1'b0;
      if (take)           out_pix   <= mixed;
    end
  end

  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_pix)));
  assert_accept_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);
  assert_pass_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !hit) |=> (out_pix == $past(in_pix)));
  assert_ones_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (take && hit && mask_row[bit_idx] && shape_row[bit_idx]) |=> (&out_pix));
  assert_zeros_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (take && hit && mask_row[bit_idx] && !shape_row[bit_idx]) |=> (out_pix == '0));
endmodule

// File: rtl/cursor_overlay.sv
module cursor_overlay
  import cursor_pkg::*;
#(
  parameter int MEM_AW  = 13,
  parameter int COORD_W = 11,
  parameter int PIX_W   = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [MEM_AW-1:0]  wr_addr,
  input  logic [15:0]        wr_data,
  input  logic               frame_start,
  input  logic [COORD_W-1:0] cur_x,
  input  logic [COORD_W-1:0] cur_y,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [COORD_W-1:0] in_x,
  input  logic [COORD_W-1:0] in_y,
  input  logic [PIX_W-1:0]   in_pix,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [PIX_W-1:0]   out_pix
);
  logic hit;
  idx_t row, col;
  row_t mask_row, shape_row;

  cursor_store #(.MEM_AW(MEM_AW)) u_store (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_row(row), .mask_row(mask_row), .shape_row(shape_row)
  );

  cursor_hit #(.COORD_W(COORD_W)) u_hit (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .cur_x(cur_x),
    .cur_y(cur_y), .pix_x(in_x), .pix_y(in_y), .hit(hit), .row(row), .col(col)
  );

  cursor_mix #(.PIX_W(PIX_W)) u_mix (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_pix(in_pix), .hit(hit), .mask_row(mask_row), .shape_row(shape_row),
    .col(col), .out_valid(out_valid), .out_ready(out_ready), .out_pix(out_pix)
  );

  assert_ready_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);
endmodule

// File: tb/tb_cursor_overlay.sv
module tb_cursor_overlay;
  localparam int CLK_PERIOD = 10;
  localparam int MEM_AW  = 13;
  localparam int COORD_W = 11;
  localparam int PIX_W   = 8;
  localparam int BASE    = (1 << MEM_AW) - 32;

  logic clk = 0, rst_n = 0;
  logic wr_en = 0; logic [MEM_AW-1:0] wr_addr = '0; logic [15:0] wr_data = '0;
  logic frame_start = 0; logic [COORD_W-1:0] cur_x = '0, cur_y = '0;
  logic in_valid = 0, in_ready; logic [COORD_W-1:0] in_x = '0, in_y = '0;
  logic [PIX_W-1:0] in_pix = '0, out_pix; logic out_valid, out_ready = 1;

  int total = 0, bad = 0; bit done = 0;
  logic [15:0] mask_tb [16];
  logic [15:0] shape_tb[16];
  int ox = 0, oy = 0;

  cursor_overlay #(.MEM_AW(MEM_AW), .COORD_W(COORD_W), .PIX_W(PIX_W)) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .frame_start(frame_start), .cur_x(cur_x), .cur_y(cur_y), .in_valid(in_valid),
    .in_ready(in_ready), .in_x(in_x), .in_y(in_y), .in_pix(in_pix),
    .out_valid(out_valid), .out_ready(out_ready), .out_pix(out_pix)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [PIX_W-1:0] model(int x, int y, logic [PIX_W-1:0] p);
    int c = x - ox, r = y - oy;
    if (c < 0 || c > 15 || r < 0 || r > 15) return p;
    if (!mask_tb[r][15-c]) return p;
    return shape_tb[r][15-c] ? '1 : '0;
  endfunction

  task automatic wr(int a, logic [15:0] d);
    @(negedge clk); wr_en = 1; wr_addr = MEM_AW'(a); wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic pixel(int x, int y, logic [PIX_W-1:0] p, string req);
    @(negedge clk); in_valid = 1; in_x = COORD_W'(x); in_y = COORD_W'(y); in_pix = p;
    @(negedge clk); in_valid = 0;
    check(req, {31'd0, out_valid}, 32'd1);
    check(req, {24'd0, out_pix}, {24'd0, model(x, y, p)});
  endtask

  task automatic set_origin(int x, int y);
    @(negedge clk); frame_start = 1; cur_x = COORD_W'(x); cur_y = COORD_W'(y);
    @(negedge clk); frame_start = 0; ox = x; oy = y;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int r = 0; r < 16; r++) begin mask_tb[r] = '0; shape_tb[r] = '0; end
    repeat (3) @(negedge clk); rst_n = 1;
    @(negedge clk);
    // R1: reset state
    check("R1 out_valid", {31'd0, out_valid}, 32'd0);
    check("R1 in_ready", {31'd0, in_ready}, 32'd1);
    pixel(0, 0, 8'h5A, "R1 passthrough");
    pixel(15, 15, 8'hC3, "R1 passthrough");
    // R2: writes below the window are ignored
    wr(BASE - 1, 16'hFFFF); wr(0, 16'hFFFF); wr(BASE - 16, 16'hFFFF);
    pixel(0, 0, 8'h77, "R2 low write ignored");
    // R2/R6: mask row 0 all set, shape row 0 clear -> zeros
    wr(BASE + 0, 16'hFFFF); mask_tb[0] = 16'hFFFF;
    pixel(0, 0, 8'h77, "R2 R6 mask row0");
    // R2/R5: shape row 0 = only leftmost set; R4 bit15 leftmost
    wr(BASE + 16, 16'h8000); shape_tb[0] = 16'h8000;
    pixel(0, 0, 8'h12, "R4 R5 leftmost column");
    pixel(1, 0, 8'h12, "R4 R6 column1");
    pixel(16, 0, 8'h12, "R3 R7 right edge outside");
    // load full patterns
    for (int r = 0; r < 16; r++) begin
      mask_tb[r]  = 16'hA5C3 ^ 16'(r * 16'h1111);
      shape_tb[r] = 16'(r * 16'h0F1D + 16'h3);
      wr(BASE + r, mask_tb[r]);
      wr(BASE + 16 + r, shape_tb[r]);
    end
    // R8: origin not taken without frame_start
    @(negedge clk); cur_x = 11'd20; cur_y = 11'd10;
    pixel(0, 0, 8'h3C, "R8 origin unchanged");
    pixel(20, 10, 8'h3C, "R8 new origin not latched");
    set_origin(20, 10);
    // R3..R7 sweep around the cursor
    for (int y = 8; y < 28; y++)
      for (int x = 18; x < 38; x++)
        pixel(x, y, 8'((x * 7 + y * 3) & 8'hFF), "R3 R4 R5 R6 R7 sweep");
    // R3: origin near zero, coordinates below origin not covered
    set_origin(0, 0);
    pixel(2047, 0, 8'h66, "R3 wrap not covered");
    // R9/R10: back-pressure
    @(negedge clk); out_ready = 0; in_valid = 1; in_x = 11'd100; in_y = 11'd100; in_pix = 8'hAB;
    @(negedge clk); in_pix = 8'hCD; in_x = 11'd101;
    check("R9 valid", {31'd0, out_valid}, 32'd1);
    check("R10 ready low", {31'd0, in_ready}, 32'd0);
    @(negedge clk);
    check("R9 hold", {24'd0, out_pix}, 32'hAB);
    check("R9 hold valid", {31'd0, out_valid}, 32'd1);
    out_ready = 1;
    #1 check("R10 ready high", {31'd0, in_ready}, 32'd1);
    @(negedge clk); in_valid = 0;
    check("R9 next", {24'd0, out_pix}, 32'hCD);
    @(negedge clk);
    check("R9 drained", {31'd0, out_valid}, 32'd0);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule